// File: doc/BRIEF.md
# Dual Class Micro-op Queue

This block sits between a decoder that produces up to three micro-ops per cycle and two independent schedulers. Each cycle it takes one input group of three slots, each slot carrying a valid bit, a class bit and a payload. It sends every valid slot into one of two first-in first-out queues: a memory queue or an arithmetic queue. While doing so it stamps each accepted micro-op with a running sequence tag. A later stage uses the tag to put results back into program order.

Each queue keeps the arrival order of its own entries. Micro-ops of one group that go to the same queue are written in slot order in the same cycle. The two queues drain through separate valid/ready output ports, so either side can run ahead of the other.

A group is taken whole or not at all. The single `in_ready` drops when either queue lacks room for the part of the group it would receive. A flush empties both queues in one cycle and restarts the tag sequence. Each queue reports its occupancy.

Top module: `uop_split_queue`

## Requirements
- R1: A valid slot whose class bit is 1 goes to the memory output port. A valid slot whose class bit is 0 goes to the arithmetic output port. Its payload comes out unchanged.
- R2: Within each queue, entries leave in arrival order. Entries of the same group leave in ascending slot order (slot 0 first).
- R3: Each queue drains independently. A queue whose ready is low neither blocks nor changes the other queue's output or count. Its own head entry and valid stay stable until taken.
- R4: `in_ready` is high only when no flush is active and each queue's free space is at least the number of valid slots of that class in the current group. When `in_ready` is low, no slot of the group enters either queue.
- R5: Each queue holds up to 16 entries. `mem_count` and `alu_count` give the number of entries held. They change on the clock edge after an accept or a pop.
- R6: Each accepted valid slot carries an 8-bit sequence tag. After reset or flush, the first tag is 0. Each later tag is one more than the previous accepted valid slot's tag, counting slots in ascending order and groups in arrival order, wrapping modulo 256.
- R7: While `flush` is high, `in_ready` is low and no group is accepted. On the next edge both queues become empty, both output valids go low, and the next accepted slot gets tag 0.
- R8: Slots with their valid bit low are ignored. They add no entry and use no tag. A group with no valid slot leaves both counts unchanged.
- R9: An output valid is high exactly when its queue is non-empty. The head's payload and tag are shown on the port while valid is high. The entry is removed on an edge where valid and ready are both high.
- R10: After reset both queues are empty, both output valids are low, both counts are 0 and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty both queues and restart tags |
| in_valid | input | 3 | Per-slot valid |
| in_class | input | 3 | Per-slot class: 1 memory, 0 arithmetic |
| in_data | input | 48 | Slot payloads, slot s at bits [16s+15:16s] |
| in_ready | output | 1 | Whole group can be accepted this cycle |
| mem_valid | output | 1 | Memory queue head present |
| mem_ready | input | 1 | Memory consumer takes head |
| mem_data | output | 16 | Memory head payload |
| mem_tag | output | 8 | Memory head sequence tag |
| alu_valid | output | 1 | Arithmetic queue head present |
| alu_ready | input | 1 | Arithmetic consumer takes head |
| alu_data | output | 16 | Arithmetic head payload |
| alu_tag | output | 8 | Arithmetic head sequence tag |
| mem_count | output | 5 | Memory queue occupancy |
| alu_count | output | 5 | Arithmetic queue occupancy |

## Verification
`in_ready` is combinational on the current group and the current counts. The bench samples it in the same cycle, shortly after driving the group on the falling edge. A group accepted at a rising edge shows up in the counts and at an empty queue's head one edge later. The bench reads those results half a cycle after that edge, before driving anything new. Pops follow the same rule: the head and valid are compared before the edge that takes the entry, and counts are compared after it. A flush is judged by `in_ready` within its own cycle and by empty queues and a restarted tag after its edge.

// File: rtl/uq_pkg.sv
package uq_pkg;

  typedef enum logic {
    CLS_ARITH = 1'b0,
    CLS_MEM   = 1'b1
  } uop_class_e;

  // number of valid slots of one class in a group (up to 8 slots)
  function automatic int unsigned count_of_class(input logic [7:0] v,
                                                 input logic [7:0] c,
                                                 input uop_class_e cls);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 8; i++)
      if (v[i] && (c[i] == logic'(cls))) n++;
    return n;
  endfunction

  // true when a queue with 'used' entries can take 'need' more
  function automatic logic has_room(input int unsigned used,
                                    input int unsigned need,
                                    input int unsigned depth);
    return (used + need) <= depth;
  endfunction

endpackage

// File: rtl/uq_steer.sv
module uq_steer #(
  parameter int SLOTS = 3,
  parameter int W     = 16,
  parameter int TAG_W = 8,
  localparam int EW   = TAG_W + W,
  localparam int NB   = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]          in_valid,
  input  logic [SLOTS-1:0]          in_class,
  input  logic [SLOTS-1:0][W-1:0]   in_data,
  input  logic [TAG_W-1:0]          base_tag,
  output logic [NB-1:0]             mem_n,
  output logic [SLOTS-1:0][EW-1:0]  mem_ent,
  output logic [NB-1:0]             alu_n,
  output logic [SLOTS-1:0][EW-1:0]  alu_ent,
  output logic [NB-1:0]             total_n
);
  // compact each class into slot order, stamping running tags
  always_comb begin
    int mi;
    int ai;
    logic [TAG_W-1:0] t;
    mem_ent = '0;
    alu_ent = '0;
    mi = 0;
    ai = 0;
    t  = base_tag;
    for (int s = 0; s < SLOTS; s++) begin
      if (in_valid[s]) begin
        if (in_class[s]) begin
          mem_ent[mi] = {t, in_data[s]};
          mi++;
        end else begin
          alu_ent[ai] = {t, in_data[s]};
          ai++;
        end
        t = t + TAG_W'(1);
      end
    end
    mem_n   = NB'(mi);
    alu_n   = NB'(ai);
    total_n = NB'(mi + ai);
  end
endmodule

// File: rtl/uq_fifo.sv
module uq_fifo #(
  parameter int DEPTH = 16,
  parameter int EW    = 24,
  parameter int NW    = 3,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NB   = $clog2(NW + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [NB-1:0]       push_n,
  input  logic [NW-1:0][EW-1:0] wr_ent,
  input  logic                rd_ready,
  output logic                rd_valid,
  output logic [EW-1:0]       rd_ent,
  output logic [CW-1:0]       count
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          pop_fire;
  logic          push_fire;

  assign rd_valid  = (count != '0);
  assign rd_ent    = mem[rp];
  assign pop_fire  = rd_valid && rd_ready && !flush;
  assign push_fire = (push_n != '0);

  // multi-entry write at the tail, in slot order
  always_ff @(posedge clk) begin
    for (int i = 0; i < NW; i++)
      if (!flush && (NB'(i) < push_n))
        mem[wp + AW'(i)] <= wr_ent[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp + AW'(push_n);
      rp    <= rp + AW'(pop_fire);
      count <= count + CW'(push_n) - CW'(pop_fire);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);
  p_push_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> (32'(count) + 32'(push_n) <= DEPTH));
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && !rd_valid);
  p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !flush) |=> rd_valid && $stable(rd_ent));
endmodule

// File: rtl/uop_split_queue.sv
module uop_split_queue #(
  parameter int SLOTS = 3,
  parameter int W     = 16,
  parameter int TAG_W = 8,
  parameter int DEPTH = 16,
  localparam int EW   = TAG_W + W,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NB   = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [SLOTS-1:0]   in_valid,
  input  logic [SLOTS-1:0]   in_class,
  input  logic [SLOTS*W-1:0] in_data,
  output logic               in_ready,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [W-1:0]       mem_data,
  output logic [TAG_W-1:0]   mem_tag,
  output logic               alu_valid,
  input  logic               alu_ready,
  output logic [W-1:0]       alu_data,
  output logic [TAG_W-1:0]   alu_tag,
  output logic [CW-1:0]      mem_count,
  output logic [CW-1:0]      alu_count
);
  import uq_pkg::*;

  logic [SLOTS-1:0][W-1:0]  slot_data;
  logic [SLOTS-1:0][EW-1:0] mem_ent, alu_ent;
  logic [NB-1:0]            mem_n, alu_n, n_valid;
  logic [NB-1:0]            mem_push, alu_push;
  logic [TAG_W-1:0]         seq_tag;
  logic [EW-1:0]            mem_head, alu_head;
  int unsigned              need_mem, need_alu;
  logic                     room_ok, accept;

  assign slot_data = in_data;

  // admission: whole group or nothing
  assign need_mem = count_of_class(8'(in_valid), 8'(in_class), CLS_MEM);
  assign need_alu = count_of_class(8'(in_valid), 8'(in_class), CLS_ARITH);
  assign room_ok  = has_room(32'(mem_count), need_mem, DEPTH) &&
                    has_room(32'(alu_count), need_alu, DEPTH);
  assign in_ready = !flush && room_ok;
  assign accept   = in_ready && (in_valid != '0);

  uq_steer #(.SLOTS(SLOTS), .W(W), .TAG_W(TAG_W)) u_steer (
    .in_valid (in_valid),
    .in_class (in_class),
    .in_data  (slot_data),
    .base_tag (seq_tag),
    .mem_n    (mem_n),
    .mem_ent  (mem_ent),
    .alu_n    (alu_n),
    .alu_ent  (alu_ent),
    .total_n  (n_valid)
  );

  assign mem_push = accept ? mem_n : '0;
  assign alu_push = accept ? alu_n : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) seq_tag <= '0;
    else if (accept)     seq_tag <= seq_tag + TAG_W'(n_valid);
  end

  uq_fifo #(.DEPTH(DEPTH), .EW(EW), .NW(SLOTS)) u_memq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_n(mem_push), .wr_ent(mem_ent),
    .rd_ready(mem_ready), .rd_valid(mem_valid), .rd_ent(mem_head),
    .count(mem_count)
  );

  uq_fifo #(.DEPTH(DEPTH), .EW(EW), .NW(SLOTS)) u_aluq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_n(alu_push), .wr_ent(alu_ent),
    .rd_ready(alu_ready), .rd_valid(alu_valid), .rd_ent(alu_head),
    .count(alu_count)
  );

  assign mem_tag  = mem_head[EW-1:W];
  assign mem_data = mem_head[W-1:0];
  assign alu_tag  = alu_head[EW-1:W];
  assign alu_data = alu_head[W-1:0];

  p_split_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(mem_n) == need_mem) && (32'(alu_n) == need_alu));
  p_ignore_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(n_valid) == $countones(in_valid));
  p_stall_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (mem_count <= $past(mem_count)) && (alu_count <= $past(alu_count)));
  p_tag_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !flush) |=> seq_tag == $past(seq_tag) + TAG_W'($past(n_valid)));
  p_flush_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (seq_tag == '0) && !in_ready || (seq_tag == '0));
endmodule

// File: tb/uop_split_queue_tb.sv
module uop_split_queue_tb;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic clk = 0, rst_n = 0, flush = 0;
  logic [2:0] in_valid = 0, in_class = 0;
  logic [47:0] in_data = 0;
  logic in_ready, mem_valid, mem_ready = 0, alu_valid, alu_ready = 0;
  logic [15:0] mem_data, alu_data;
  logic [7:0] mem_tag, alu_tag;
  logic [4:0] mem_count, alu_count;

  int total = 0, bad = 0;
  logic [23:0] mq[$], aq[$];
  logic [7:0] tagc = 0;
  int dseed = 100;

  uop_split_queue u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_class(in_class), .in_data(in_data),
    .in_ready(in_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_data(mem_data), .mem_tag(mem_tag),
    .alu_valid(alu_valid), .alu_ready(alu_ready), .alu_data(alu_data), .alu_tag(alu_tag),
    .mem_count(mem_count), .alu_count(alu_count)
  );

  always #(CLK_P/2) clk = ~clk;

  // {valid, class, expected mem count after, expected alu count after}
  localparam logic [15:0] VEC [8] = '{
    {3'b111, 3'b000, 5'd0, 5'd3},
    {3'b111, 3'b111, 5'd3, 5'd3},
    {3'b101, 3'b001, 5'd4, 5'd4},
    {3'b010, 3'b010, 5'd5, 5'd4},
    {3'b111, 3'b101, 5'd7, 5'd5},
    {3'b011, 3'b010, 5'd8, 5'd6},
    {3'b100, 3'b100, 5'd9, 5'd6},
    {3'b000, 3'b111, 5'd9, 5'd6}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one group; returns sampled in_ready; model updated on accept
  task automatic drive(input logic [2:0] v, input logic [2:0] c, output bit rdy);
    @(negedge clk);
    in_valid = v;
    in_class = c;
    for (int s = 0; s < 3; s++) in_data[s*W +: W] = 16'(dseed + s);
    #1;
    rdy = in_ready;
    if (rdy && !flush) begin
      for (int s = 0; s < 3; s++)
        if (v[s]) begin
          if (c[s]) mq.push_back({tagc, 16'(dseed + s)});
          else      aq.push_back({tagc, 16'(dseed + s)});
          tagc++;
        end
    end
    dseed += 8;
    @(posedge clk);
    #1;
    in_valid = 0;
  endtask

  task automatic pop_one(input bit is_mem, input string req);
    logic [23:0] e;
    @(negedge clk);
    if (is_mem) mem_ready = 1; else alu_ready = 1;
    #1;
    e = is_mem ? mq[0] : aq[0];
    if (is_mem) begin
      chk(mem_valid, req, "mem_valid", int'(mem_valid), 1);
      chk(mem_data == e[15:0], req, "mem_data", int'(mem_data), int'(e[15:0]));
      chk(mem_tag == e[23:16], req, "mem_tag", int'(mem_tag), int'(e[23:16]));
      void'(mq.pop_front());
    end else begin
      chk(alu_valid, req, "alu_valid", int'(alu_valid), 1);
      chk(alu_data == e[15:0], req, "alu_data", int'(alu_data), int'(e[15:0]));
      chk(alu_tag == e[23:16], req, "alu_tag", int'(alu_tag), int'(e[23:16]));
      void'(aq.pop_front());
    end
    @(posedge clk);
    #1;
    mem_ready = 0;
    alu_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit rdy;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!mem_valid && !alu_valid, "R10", "valids", int'({mem_valid, alu_valid}), 0);
    chk(mem_count == 0 && alu_count == 0, "R10", "counts", int'({mem_count, alu_count}), 0);
    chk(in_ready, "R10", "in_ready", int'(in_ready), 1);

    // table walk: R1 R5 R8 steering and occupancy
    for (int k = 0; k < 8; k++) begin
      drive(VEC[k][15:13], VEC[k][12:10], rdy);
      chk(rdy, "R4", "in_ready with room", int'(rdy), 1);
      chk(mem_count == VEC[k][9:5], "R5", "mem_count", int'(mem_count), int'(VEC[k][9:5]));
      chk(alu_count == VEC[k][4:0], "R8", "alu_count", int'(alu_count), int'(VEC[k][4:0]));
    end
    // R3: drain arithmetic side only; memory side untouched
    n = aq.size();
    for (int k = 0; k < n; k++) pop_one(0, "R2");
    @(negedge clk);
    chk(mem_count == 9, "R3", "mem_count held", int'(mem_count), 9);
    chk(mem_valid && mem_tag == mq[0][23:16], "R3", "mem head held", int'(mem_tag), int'(mq[0][23:16]));
    chk(!alu_valid, "R9", "alu_valid empty", int'(alu_valid), 0);
    n = mq.size();
    for (int k = 0; k < n; k++) pop_one(1, "R6");
    @(negedge clk);
    chk(!mem_valid && mem_count == 0, "R9", "mem empty", int'(mem_count), 0);

    // R4: fill memory queue to 15
    for (int k = 0; k < 5; k++) drive(3'b111, 3'b111, rdy);
    chk(mem_count == 15, "R5", "mem_count fill", int'(mem_count), 15);
    drive(3'b111, 3'b111, rdy);
    chk(!rdy, "R4", "in_ready no room", int'(rdy), 0);
    chk(mem_count == 15 && alu_count == 0, "R4", "no partial write", int'(alu_count), 0);
    drive(3'b111, 3'b001, rdy);
    chk(rdy, "R4", "mixed group fits", int'(rdy), 1);
    chk(mem_count == 16 && alu_count == 2, "R5", "counts at full", int'(mem_count), 16);
    drive(3'b111, 3'b000, rdy);
    chk(rdy, "R3", "arith accepted while mem full", int'(rdy), 1);
    drive(3'b011, 3'b010, rdy);
    chk(!rdy, "R4", "group stalls on mem side", int'(rdy), 0);
    chk(alu_count == 5, "R4", "alu untouched by stalled group", int'(alu_count), 5);
    pop_one(0, "R3");
    pop_one(0, "R2");
    @(negedge clk);
    chk(mem_count == 16, "R3", "mem stays full", int'(mem_count), 16);
    pop_one(1, "R2");
    pop_one(1, "R1");

    // R7 flush with a group offered in the same cycle
    @(negedge clk);
    flush = 1;
    in_valid = 3'b111;
    in_class = 3'b010;
    #1;
    chk(!in_ready, "R7", "in_ready during flush", int'(in_ready), 0);
    @(posedge clk);
    #1;
    flush = 0;
    in_valid = 0;
    mq.delete();
    aq.delete();
    tagc = 0;
    @(negedge clk);
    chk(mem_count == 0 && alu_count == 0, "R7", "counts after flush", int'({mem_count, alu_count}), 0);
    chk(!mem_valid && !alu_valid, "R7", "valids after flush", int'({mem_valid, alu_valid}), 0);
    drive(3'b110, 3'b100, rdy);
    pop_one(0, "R7");
    pop_one(1, "R6");
    @(negedge clk);
    chk(mem_count == 0 && alu_count == 0, "R9", "drained", int'({mem_count, alu_count}), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule